// File: doc/BRIEF.md
# Four-Bit Processor Instruction Decoder

This block decodes the first byte of an instruction for a processor with a four-bit accumulator. It splits the byte into an upper opcode nibble and a lower modifier nibble. It then places the instruction in one of nine operand layouts. It reports whether a second byte, either an address or a data byte, must follow. It also pulls out whichever operand the low nibble carries: a register number, a register-pair number, four bits of immediate data, a jump-condition mask or the top four address bits. The same low nibble means different things depending on the opcode. For the two pair-based opcode rows, its lowest bit selects between two unrelated instructions.

Decoding is combinational. All results pass through one output register stage. A byte offered with `in_valid` high appears on the outputs one clock later with `out_valid` high. When no byte is offered, the outputs keep their last decoded values and `out_valid` drops. Every operation also drives its own bit of a one-hot strobe vector. The two unused codes at the top of the accumulator row raise an illegal flag and decode as the no-operation.

Top module: `nibble_insn_decoder`

## Requirements
- R1: A synchronous active-high `rst` makes `out_valid` 0 and sets every decoded output to zero on the next rising edge.
- R2: `out_valid` equals the `in_valid` of the previous edge. When `in_valid` is low, all decoded outputs keep their previous values.
- R3: `out_fmt` uses these layout codes: 0 = single register, 1 = pair with bit0 clear, 2 = pair with bit0 set, 3 = 4-bit immediate, 4 = no operand, 5 = 12-bit address, 6 = condition plus address byte, 7 = register plus address byte, 8 = pair plus data byte. The layout depends on the upper nibble `u` and low bit `b0`:
  - `u`=0: code 4
  - `u`=1: code 6
  - `u`=2: code 8 when `b0`=0, code 2 when `b0`=1
  - `u`=3: code 1 when `b0`=0, code 2 when `b0`=1
  - `u`=4 or 5: code 5
  - `u`=6, 8, 9, A or B: code 0
  - `u`=7: code 7
  - `u`=C or D: code 3
  - `u`=E or F: code 4
- R4: `out_two_word` is 1 exactly for upper nibbles 1, 4, 5 and 7, and for upper nibble 2 with bit0 = 0.
- R5: `out_reg_idx` carries the low nibble for upper nibbles 6 through B and is zero otherwise.
- R6: `out_pair_idx` carries bits 3:1 for upper nibbles 2 and 3 and is zero otherwise.
- R7: Three further fields carry the low nibble for their own rows and are zero otherwise:
  - `out_imm` for upper nibbles C and D
  - `out_cond` for upper nibble 1
  - `out_addr_hi` for upper nibbles 4 and 5
- R8: `out_op_onehot` has exactly one bit set while `out_valid` is high. The bit index depends on the upper nibble `u` and low nibble `l`:
  - `u`=0: bit 0
  - `u`=1: bit 1
  - `u`=2: bit 2 + `b0`
  - `u`=3: bit 4 + `b0`
  - `u`=4 through D: bit `u` + 2, so 4→6 and D→15
  - `u`=E: bit 16 + `l`
  - `u`=F with `l` ≤ D: bit 32 + `l`
- R9: Bytes 0xFE and 0xFF set `out_illegal` and decode as the no-operation: strobe bit 0, layout 4, no second byte and all fields zero. `out_illegal` is 0 for every other byte.
- R10: Within upper nibbles 2 and 3, flipping only bit0 changes the strobe bit and the layout but leaves `out_pair_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered this cycle |
| in_byte | input | 8 | First instruction byte |
| out_valid | output | 1 | Decoded results valid |
| out_fmt | output | 4 | Operand layout code (R3) |
| out_two_word | output | 1 | A second byte must be fetched |
| out_illegal | output | 1 | Undefined opcode seen |
| out_reg_idx | output | 4 | Register number |
| out_pair_idx | output | 3 | Register-pair number |
| out_imm | output | 4 | Immediate data nibble |
| out_cond | output | 4 | Jump condition mask |
| out_addr_hi | output | 4 | Upper address bits |
| out_op_onehot | output | 46 | One strobe per operation (R8) |

## Verification
Every decoded result, including the strobe vector, is due exactly one rising edge after the byte is offered. No result is due sooner or later. The bench therefore drives a byte on a falling edge, waits for one rising edge and compares on the following falling edge. It then offers the next byte at that same falling edge, so back-to-back bytes are each checked in their own cycle. The hold and reset cases use the same one-edge spacing: outputs are compared one edge after `in_valid` drops or `rst` is asserted.

// File: rtl/nid_pkg.sv
package nid_pkg;
    localparam int INSN_W  = 8;
    localparam int NIB_W   = INSN_W / 2;
    localparam int PAIR_W  = NIB_W - 1;
    localparam int NUM_OPS = 46;
    localparam int OP_W    = $clog2(NUM_OPS);
    localparam int IO_BASE = 16;
    localparam int ACC_BASE = 32;
    localparam int ACC_LAST = 13;

    typedef enum logic [3:0] {
        FMT_REG       = 4'd0,
        FMT_PAIR_LO0  = 4'd1,
        FMT_PAIR_LO1  = 4'd2,
        FMT_IMM4      = 4'd3,
        FMT_NONE      = 4'd4,
        FMT_LONG_ADDR = 4'd5,
        FMT_COND_ADDR = 4'd6,
        FMT_REG_ADDR  = 4'd7,
        FMT_PAIR_DATA = 4'd8
    } fmt_e;

    typedef struct packed {
        fmt_e              fmt;
        logic              two_word;
        logic              illegal;
        logic [OP_W-1:0]   op_idx;
    } class_t;

    typedef struct packed {
        logic [NIB_W-1:0]  reg_idx;
        logic [PAIR_W-1:0] pair_idx;
        logic [NIB_W-1:0]  imm;
        logic [NIB_W-1:0]  cond;
        logic [NIB_W-1:0]  addr_hi;
    } fields_t;

    function automatic logic fmt_has_reg(fmt_e f);
        return (f == FMT_REG) || (f == FMT_REG_ADDR);
    endfunction

    function automatic logic fmt_has_pair(fmt_e f);
        return (f == FMT_PAIR_LO0) || (f == FMT_PAIR_LO1) || (f == FMT_PAIR_DATA);
    endfunction

    function automatic logic fmt_needs_second(fmt_e f);
        return (f == FMT_LONG_ADDR) || (f == FMT_COND_ADDR) ||
               (f == FMT_REG_ADDR)  || (f == FMT_PAIR_DATA);
    endfunction
endpackage

// File: rtl/nid_classify.sv
module nid_classify
    import nid_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output class_t            cls
);
    logic [NIB_W-1:0] upper;
    logic [NIB_W-1:0] lower;
    logic             b0;

    assign upper = insn[INSN_W-1:NIB_W];
    assign lower = insn[NIB_W-1:0];
    assign b0    = lower[0];

    always_comb begin
        cls.fmt      = FMT_NONE;
        cls.two_word = 1'b0;
        cls.illegal  = 1'b0;
        cls.op_idx   = '0;
        unique case (upper)
            4'h0: begin cls.fmt = FMT_NONE;      cls.op_idx = OP_W'(0); end
            4'h1: begin cls.fmt = FMT_COND_ADDR; cls.op_idx = OP_W'(1); cls.two_word = 1'b1; end
            4'h2: begin
                cls.fmt      = b0 ? FMT_PAIR_LO1 : FMT_PAIR_DATA;
                cls.op_idx   = OP_W'(2 + int'(b0));
                cls.two_word = ~b0;
            end
            4'h3: begin
                cls.fmt    = b0 ? FMT_PAIR_LO1 : FMT_PAIR_LO0;
                cls.op_idx = OP_W'(4 + int'(b0));
            end
            4'h4, 4'h5: begin
                cls.fmt      = FMT_LONG_ADDR;
                cls.op_idx   = OP_W'(int'(upper) + 2);
                cls.two_word = 1'b1;
            end
            4'h7: begin
                cls.fmt      = FMT_REG_ADDR;
                cls.op_idx   = OP_W'(9);
                cls.two_word = 1'b1;
            end
            4'h6, 4'h8, 4'h9, 4'hA, 4'hB: begin
                cls.fmt    = FMT_REG;
                cls.op_idx = OP_W'(int'(upper) + 2);
            end
            4'hC, 4'hD: begin
                cls.fmt    = FMT_IMM4;
                cls.op_idx = OP_W'(int'(upper) + 2);
            end
            4'hE: begin
                cls.fmt    = FMT_NONE;
                cls.op_idx = OP_W'(IO_BASE + int'(lower));
            end
            default: begin
                cls.fmt = FMT_NONE;
                if (int'(lower) <= ACC_LAST) begin
                    cls.op_idx = OP_W'(ACC_BASE + int'(lower));
                end else begin
                    cls.op_idx  = OP_W'(0);
                    cls.illegal = 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        assert_two_word_row_R4: assert (cls.two_word == fmt_needs_second(cls.fmt));
    end
endmodule

// File: rtl/nid_fields.sv
module nid_fields
    import nid_pkg::*;
(
    input  logic [NIB_W-1:0] lower,
    input  fmt_e             fmt,
    output fields_t          fld
);
    always_comb begin
        fld.reg_idx  = fmt_has_reg(fmt)          ? lower : '0;
        fld.pair_idx = fmt_has_pair(fmt)         ? lower[NIB_W-1:1] : '0;
        fld.imm      = (fmt == FMT_IMM4)         ? lower : '0;
        fld.cond     = (fmt == FMT_COND_ADDR)    ? lower : '0;
        fld.addr_hi  = (fmt == FMT_LONG_ADDR)    ? lower : '0;
    end
endmodule

// File: rtl/nid_strobe.sv
module nid_strobe
    import nid_pkg::*;
(
    input  logic [OP_W-1:0]    op_idx,
    output logic [NUM_OPS-1:0] onehot
);
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_strobe
        assign onehot[g] = (op_idx == OP_W'(g));
    end
endmodule

// File: rtl/nid_out_reg.sv
module nid_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/nibble_insn_decoder.sv
module nibble_insn_decoder
    import nid_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSN_W-1:0]   in_byte,
    output logic                out_valid,
    output logic [3:0]          out_fmt,
    output logic                out_two_word,
    output logic                out_illegal,
    output logic [NIB_W-1:0]    out_reg_idx,
    output logic [PAIR_W-1:0]   out_pair_idx,
    output logic [NIB_W-1:0]    out_imm,
    output logic [NIB_W-1:0]    out_cond,
    output logic [NIB_W-1:0]    out_addr_hi,
    output logic [NUM_OPS-1:0]  out_op_onehot
);
    localparam int CLS_W = $bits(class_t);
    localparam int FLD_W = $bits(fields_t);
    localparam int REG_W = CLS_W + FLD_W + NUM_OPS;

    class_t              cls_c;
    fields_t             fld_c;
    logic [NUM_OPS-1:0]  hot_c;
    logic [REG_W-1:0]    stage_d;
    logic [REG_W-1:0]    stage_q;
    class_t              cls_q;
    fields_t             fld_q;
    logic [OP_W-1:0]     op_q_unused;

    nid_classify u_classify (
        .insn (in_byte),
        .cls  (cls_c)
    );

    nid_fields u_fields (
        .lower (in_byte[NIB_W-1:0]),
        .fmt   (cls_c.fmt),
        .fld   (fld_c)
    );

    nid_strobe u_strobe (
        .op_idx (cls_c.op_idx),
        .onehot (hot_c)
    );

    assign stage_d = {cls_c, fld_c, hot_c};

    nid_out_reg #(.W(REG_W)) u_out_reg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (stage_d),
        .q_valid  (out_valid),
        .q        (stage_q)
    );

    assign {cls_q, fld_q, out_op_onehot} = stage_q;
    assign op_q_unused   = cls_q.op_idx;
    assign out_fmt       = cls_q.fmt;
    assign out_two_word  = cls_q.two_word;
    assign out_illegal   = cls_q.illegal;
    assign out_reg_idx   = fld_q.reg_idx;
    assign out_pair_idx  = fld_q.pair_idx;
    assign out_imm       = fld_q.imm;
    assign out_cond      = fld_q.cond;
    assign out_addr_hi   = fld_q.addr_hi;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_op_onehot == '0 && out_fmt == 4'd0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_op_onehot) && $stable(out_fmt) && $stable(out_reg_idx)));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_op_onehot) == 1);

    assert_illegal_is_nop_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_op_onehot[0] && !out_two_word &&
                                        out_fmt == 4'd4));

    assert_reg_field_excl_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_reg_idx != '0) |-> (out_fmt == 4'd0 || out_fmt == 4'd7));

    assert_op_matches_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_op_onehot[op_q_unused]);
endmodule

// File: tb/nibble_insn_decoder_tb_top.sv
module nibble_insn_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [3:0]  out_fmt;
    logic        out_two_word;
    logic        out_illegal;
    logic [3:0]  out_reg_idx;
    logic [2:0]  out_pair_idx;
    logic [3:0]  out_imm;
    logic [3:0]  out_cond;
    logic [3:0]  out_addr_hi;
    logic [45:0] out_op_onehot;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    nibble_insn_decoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_fmt(out_fmt), .out_two_word(out_two_word),
        .out_illegal(out_illegal), .out_reg_idx(out_reg_idx),
        .out_pair_idx(out_pair_idx), .out_imm(out_imm), .out_cond(out_cond),
        .out_addr_hi(out_addr_hi), .out_op_onehot(out_op_onehot)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirement text
    function automatic int e_fmt(logic [7:0] b);
        logic [3:0] u = b[7:4];
        case (u)
            4'h0: return 4;
            4'h1: return 6;
            4'h2: return b[0] ? 2 : 8;
            4'h3: return b[0] ? 2 : 1;
            4'h4, 4'h5: return 5;
            4'h7: return 7;
            4'hC, 4'hD: return 3;
            4'hE, 4'hF: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int e_op(logic [7:0] b);
        logic [3:0] u = b[7:4];
        logic [3:0] l = b[3:0];
        if (u == 4'h0) return 0;
        if (u == 4'h1) return 1;
        if (u == 4'h2) return 2 + int'(b[0]);
        if (u == 4'h3) return 4 + int'(b[0]);
        if (u == 4'hE) return 16 + int'(l);
        if (u == 4'hF) return (l <= 4'hD) ? 32 + int'(l) : 0;
        return int'(u) + 2;
    endfunction

    task automatic offer(logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_byte(logic [7:0] b);
        logic [3:0] u = b[7:4];
        logic [3:0] l = b[3:0];
        logic ill = (b == 8'hFE) || (b == 8'hFF);
        chk("R2", "valid", 64'(out_valid), 64'd1);
        chk("R3", "fmt", 64'(out_fmt), 64'(e_fmt(b)));
        chk("R4", "two_word", 64'(out_two_word),
            64'(u == 4'h1 || u == 4'h4 || u == 4'h5 || u == 4'h7 || (u == 4'h2 && !b[0])));
        chk("R5", "reg_idx", 64'(out_reg_idx), 64'((u >= 4'h6 && u <= 4'hB) ? l : 4'h0));
        chk("R6", "pair_idx", 64'(out_pair_idx), 64'((u == 4'h2 || u == 4'h3) ? l[3:1] : 3'h0));
        chk("R7", "imm", 64'(out_imm), 64'((u == 4'hC || u == 4'hD) ? l : 4'h0));
        chk("R7", "cond", 64'(out_cond), 64'((u == 4'h1) ? l : 4'h0));
        chk("R7", "addr_hi", 64'(out_addr_hi), 64'((u == 4'h4 || u == 4'h5) ? l : 4'h0));
        chk("R8", "onehot", 64'(out_op_onehot), 64'd1 << e_op(b));
        chk("R9", "illegal", 64'(out_illegal), 64'(ill));
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid after reset", 64'(out_valid), 64'd0);
        chk("R1", "onehot after reset", 64'(out_op_onehot), 64'd0);
        chk("R1", "fmt after reset", 64'(out_fmt), 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 256; i++) begin
            offer(8'(i));
            check_byte(8'(i));
        end
    endtask

    task automatic t_pair_split();
        offer(8'h2A); check_byte(8'h2A);
        offer(8'h2B); check_byte(8'h2B);
        chk("R10", "pair kept 2B", 64'(out_pair_idx), 64'd5);
        chk("R10", "strobe 2B", 64'(out_op_onehot), 64'd1 << 3);
        offer(8'h36);
        chk("R10", "strobe 36", 64'(out_op_onehot), 64'd1 << 4);
        offer(8'h37);
        chk("R10", "pair kept 37", 64'(out_pair_idx), 64'd3);
        chk("R10", "fmt 37", 64'(out_fmt), 64'd2);
    endtask

    task automatic t_illegal();
        offer(8'hFE); check_byte(8'hFE);
        chk("R9", "FE fmt", 64'(out_fmt), 64'd4);
        offer(8'hFD);
        chk("R9", "FD legal", 64'(out_illegal), 64'd0);
        chk("R8", "FD strobe", 64'(out_op_onehot), 64'd1 << 45);
        offer(8'hFF);
        chk("R9", "FF nop strobe", 64'(out_op_onehot), 64'd1);
    endtask

    task automatic t_hold();
        offer(8'h7A);
        in_valid = 1'b0;
        in_byte  = 8'hD5;
        @(posedge clk);
        @(negedge clk);
        chk("R2", "valid drops", 64'(out_valid), 64'd0);
        chk("R2", "reg held", 64'(out_reg_idx), 64'hA);
        chk("R2", "imm held", 64'(out_imm), 64'd0);
        chk("R2", "onehot held", 64'(out_op_onehot), 64'd1 << 9);
    endtask

    task automatic t_reset_mid();
        offer(8'h53);
        rst = 1'b1; in_valid = 1'b1; in_byte = 8'h1C;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "valid cleared", 64'(out_valid), 64'd0);
        chk("R1", "addr cleared", 64'(out_addr_hi), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sweep();
        t_pair_split();
        t_illegal();
        t_hold();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule